// File: doc/BRIEF.md
# Clock-Synchronous Serial Master Engine

This block is the master side of a clock-synchronous serial link. A word placed in a single-entry transmit holding register is moved into a shift register and sent out on a data line. The block generates the serial clock itself. On each clock it drives one outgoing bit and samples one incoming bit, so every word sent also brings back a word of the same length, which lands in a receive data register.

The bit rate comes from outside as a `tick` strobe. Each strobe is half a bit time and moves the serial clock by one edge. A 3-bit length code selects words of 5 to 9 bits. A 2-bit wait code can hold the clock idle for up to three bit times between back-to-back words. Status flags report an empty transmit register, an idle transmitter, a full receive register and receive overrun. Enable-gated interrupt requests are built from these flags. A soft-reset pulse aborts the current transfer, and a force-high pulse parks the data output at 1.

Top module: `csm_master`

## Requirements
- R1: The length code `len_code` selects the word length: 3'b000 gives 8 bits, 3'b001 gives 5, 3'b010 gives 6, 3'b011 gives 7 and 3'b100 gives 9. The codes 3'b101 to 3'b111 are illegal and behave as 8 bits.
- R2: When another word is already waiting as a word completes, the wait code `wait_code` (0 to 3) sets the idle time before it starts. The serial clock stays high for `wait_code` extra bit times (2*`wait_code` ticks). Code 0 gives a continuous clock: the next falling edge comes on the tick right after the last rising edge.
- R3: `tx_empty` goes to 0 on the clock after an accepted write. It returns to 1 on the clock after the tick that moves the word into the shift register and starts it.
- R4: `tx_idle` is 1 only when the transmit register is empty and no word is being shifted or waiting out its gap. A write clears it on the next clock.
- R5: A received word is stored right-aligned in the 9-bit `rx_data`, with the first received bit as the most significant of the selected length. All bits above the length read as 0.
- R6: `rx_full` sets on the clock after a word completes and clears on the clock after an `rx_rd` pulse. `rx_irq` equals `rx_full` AND `rx_ie`.
- R7: A word that completes while `rx_full` is 1 sets the sticky `rx_ovr` flag and leaves `rx_data` unchanged. Only `soft_rst` clears `rx_ovr`.
- R8: A `soft_rst` pulse stops any transfer. On the next clock it returns the serial clock high, empties the transmit register and clears `rx_ovr`.
- R9: A `force_high` pulse drives `sdo` to 1 on the next clock.
- R10: The serial clock idles high. Bits go out most significant bit (of the selected length) first. `sdo` changes with each falling serial-clock edge, and `sdi` is sampled on the tick that makes each rising edge. `sclk` only changes on a tick or a soft reset.
- R11: A write while the transmit register still holds a word is ignored.
- R12: Out of reset: `sclk`=1, `sdo`=1, `tx_empty`=1, `tx_idle`=1, `rx_full`=0, `rx_ovr`=0 and `rx_data`=0.
- R13: `tx_irq` = (`tx_empty` AND `tx_ie`) OR (`tx_idle` AND `idle_ie`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Half-bit-time strobe from the rate generator |
| len_code | input | 3 | Word length code |
| wait_code | input | WAIT_W | Inter-word idle in bit times |
| rx_ie | input | 1 | Receive interrupt enable |
| tx_ie | input | 1 | Transmit-empty interrupt enable |
| idle_ie | input | 1 | Transmitter-idle interrupt enable |
| tx_wr | input | 1 | Write strobe for the transmit register |
| tx_wdata | input | WORD_W | Transmit word, right-aligned |
| rx_rd | input | 1 | Read strobe for the receive register |
| soft_rst | input | 1 | Abort transfer and empty transmit register |
| force_high | input | 1 | Drive the data output to 1 |
| sdi | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Serial data out |
| rx_data | output | WORD_W | Received word, zero-filled above the length |
| rx_full | output | 1 | Receive register holds an unread word |
| rx_ovr | output | 1 | Sticky receive overrun |
| tx_empty | output | 1 | Transmit register is free |
| tx_idle | output | 1 | Transmitter has nothing in flight |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The bench builds the block with its defaults: a 9-bit word and a 2-bit wait code. This reaches every length code, including the illegal ones, and every gap from 0 to 3 bit times. A tick every second clock keeps a whole 9-bit word within about forty cycles, so every length and every gap can be run back to back in one short run. Looping `sdo` back into `sdi` makes the truncation and zero fill of each length directly visible in `rx_data`. Stopping the tick lets a second write land while the holding register is still full.

// File: rtl/csm_pkg.sv
package csm_pkg;
    localparam int WORD_W = 9;
    localparam int IDX_W  = 4;
    localparam int LEN_W  = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } seq_state_e;

    // events raised by the sequencer for the data paths, valid for one clock
    typedef struct packed {
        logic             load;   // holding word enters the shifter (also a fall)
        logic             fall;   // serial clock falls, next bit goes out
        logic             rise;   // serial clock rises, input bit is taken
        logic             last;   // rise that completes the word
        logic [IDX_W-1:0] didx;   // bit index driven on this fall
    } shift_ev_t;

    function automatic logic [IDX_W-1:0] word_bits(input logic [LEN_W-1:0] code);
        case (code)
            3'b001:  word_bits = IDX_W'(5);
            3'b010:  word_bits = IDX_W'(6);
            3'b011:  word_bits = IDX_W'(7);
            3'b100:  word_bits = IDX_W'(9);
            default: word_bits = IDX_W'(8);
        endcase
    endfunction
endpackage

// File: rtl/csm_seq.sv
module csm_seq
    import csm_pkg::*;
#(
    parameter int WAIT_W = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 soft_rst,
    input  logic                 word_avail,
    input  logic [LEN_W-1:0]     len_code,
    input  logic [WAIT_W-1:0]    wait_code,
    output shift_ev_t            ev,
    output logic                 sclk,
    output logic                 busy
);
    localparam int GAP_W = WAIT_W + 1;

    seq_state_e       st;
    logic [IDX_W-1:0] idx;
    logic [GAP_W-1:0] gcnt;

    always_comb begin
        ev = '0;
        if (tick && !soft_rst) begin
            case (st)
                ST_IDLE: begin
                    if (word_avail) begin
                        ev.load = 1'b1;
                        ev.fall = 1'b1;
                        ev.didx = word_bits(len_code) - IDX_W'(1);
                    end
                end
                ST_SHIFT: begin
                    if (sclk) begin
                        ev.fall = 1'b1;
                        ev.didx = idx - IDX_W'(1);
                    end else begin
                        ev.rise = 1'b1;
                        ev.last = (idx == '0);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            st   <= ST_IDLE;
            sclk <= 1'b1;
            idx  <= '0;
            gcnt <= '0;
        end else if (tick) begin
            case (st)
                ST_IDLE: begin
                    if (ev.load) begin
                        st   <= ST_SHIFT;
                        sclk <= 1'b0;
                        idx  <= ev.didx;
                    end
                end
                ST_SHIFT: begin
                    if (sclk) begin
                        sclk <= 1'b0;
                        idx  <= ev.didx;
                    end else begin
                        sclk <= 1'b1;
                        if (ev.last) begin
                            if (wait_code == '0) begin
                                st <= ST_IDLE;
                            end else begin
                                st   <= ST_GAP;
                                gcnt <= {wait_code, 1'b0};
                            end
                        end
                    end
                end
                ST_GAP: begin
                    gcnt <= gcnt - GAP_W'(1);
                    if (gcnt == GAP_W'(1)) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy = (st != ST_IDLE);

    // R10
    sclk_idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> sclk);

    // R10
    sclk_tick_only_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sclk) |-> ($past(tick) || $past(soft_rst)));

    // R2
    gap_no_clock_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_GAP) |-> sclk);
endmodule

// File: rtl/csm_txbuf.sv
module csm_txbuf
    import csm_pkg::*;
#(
    parameter int WORD_W = csm_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              tx_wr,
    input  logic [WORD_W-1:0] tx_wdata,
    input  logic              force_high,
    input  shift_ev_t         ev,
    output logic              valid,
    output logic              sdo
);
    logic [WORD_W-1:0] thr;
    logic [WORD_W-1:0] shw;

    always_ff @(posedge clk) begin
        if (rst) begin
            thr   <= '1;
            shw   <= '1;
            valid <= 1'b0;
            sdo   <= 1'b1;
        end else begin
            if (soft_rst) begin
                valid <= 1'b0;
            end else if (ev.load) begin
                valid <= 1'b0;
                shw   <= thr;
            end else if (tx_wr && !valid) begin
                thr   <= tx_wdata;
                valid <= 1'b1;
            end

            if (force_high) begin
                sdo <= 1'b1;
            end else if (ev.fall) begin
                sdo <= ev.load ? thr[ev.didx] : shw[ev.didx];
            end
        end
    end

    // R11
    full_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_wr && valid) |=> (thr == $past(thr)));

    // R3
    load_empties_chk: assert property (@(posedge clk) disable iff (rst)
        ev.load |=> !valid);

    // R9
    force_high_chk: assert property (@(posedge clk) disable iff (rst)
        force_high |=> sdo);
endmodule

// File: rtl/csm_rxbuf.sv
module csm_rxbuf
    import csm_pkg::*;
#(
    parameter int WORD_W = csm_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              sdi,
    input  logic              rx_rd,
    input  shift_ev_t         ev,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_full,
    output logic              rx_ovr
);
    logic [WORD_W-1:0] rsh;
    logic [WORD_W-1:0] word;

    assign word = {rsh[WORD_W-2:0], sdi};

    always_ff @(posedge clk) begin
        if (rst) begin
            rsh     <= '0;
            rx_data <= '0;
            rx_full <= 1'b0;
            rx_ovr  <= 1'b0;
        end else begin
            if (ev.load)      rsh <= '0;
            else if (ev.rise) rsh <= word;

            if (ev.last && !rx_full) begin
                rx_data <= word;
                rx_full <= 1'b1;
            end else if (rx_rd) begin
                rx_full <= 1'b0;
            end

            if (soft_rst)                rx_ovr <= 1'b0;
            else if (ev.last && rx_full) rx_ovr <= 1'b1;
        end
    end

    // R7
    overrun_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.last && rx_full) |=> (rx_ovr && $stable(rx_data)));

    // R6
    full_until_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_full && !rx_rd) |=> rx_full);
endmodule

// File: rtl/csm_master.sv
module csm_master
    import csm_pkg::*;
#(
    parameter int WORD_W = csm_pkg::WORD_W,
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [2:0]        len_code,
    input  logic [WAIT_W-1:0] wait_code,
    input  logic              rx_ie,
    input  logic              tx_ie,
    input  logic              idle_ie,
    input  logic              tx_wr,
    input  logic [WORD_W-1:0] tx_wdata,
    input  logic              rx_rd,
    input  logic              soft_rst,
    input  logic              force_high,
    input  logic              sdi,
    output logic              sclk,
    output logic              sdo,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_full,
    output logic              rx_ovr,
    output logic              tx_empty,
    output logic              tx_idle,
    output logic              rx_irq,
    output logic              tx_irq
);
    shift_ev_t ev;
    logic      hold_valid;
    logic      busy;

    csm_seq #(.WAIT_W(WAIT_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .soft_rst   (soft_rst),
        .word_avail (hold_valid),
        .len_code   (len_code),
        .wait_code  (wait_code),
        .ev         (ev),
        .sclk       (sclk),
        .busy       (busy)
    );

    csm_txbuf #(.WORD_W(WORD_W)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .soft_rst   (soft_rst),
        .tx_wr      (tx_wr),
        .tx_wdata   (tx_wdata),
        .force_high (force_high),
        .ev         (ev),
        .valid      (hold_valid),
        .sdo        (sdo)
    );

    csm_rxbuf #(.WORD_W(WORD_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .sdi      (sdi),
        .rx_rd    (rx_rd),
        .ev       (ev),
        .rx_data  (rx_data),
        .rx_full  (rx_full),
        .rx_ovr   (rx_ovr)
    );

    assign tx_empty = !hold_valid;
    assign tx_idle  = !hold_valid && !busy;
    assign rx_irq   = rx_full && rx_ie;
    assign tx_irq   = (tx_empty && tx_ie) || (tx_idle && idle_ie);

    // R4
    idle_needs_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_idle && !tick) |=> $stable(sclk));

    // R8
    soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (sclk && tx_empty && !rx_ovr));
endmodule

// File: tb/csm_master_bench.sv
module csm_master_bench;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst = 1'b1, tick = 1'b0;
    logic [2:0] len_code = 3'b000;
    logic [1:0] wait_code = 2'b00;
    logic       rx_ie = 1'b0, tx_ie = 1'b0, idle_ie = 1'b0;
    logic       tx_wr = 1'b0, rx_rd = 1'b0, soft_rst = 1'b0, force_high = 1'b0;
    logic [8:0] tx_wdata = '0;
    logic       sdi = 1'b0;
    logic       sclk, sdo, rx_full, rx_ovr, tx_empty, tx_idle, rx_irq, tx_irq;
    logic [8:0] rx_data;

    csm_master u_csm_master (
        .clk(clk), .rst(rst), .tick(tick), .len_code(len_code), .wait_code(wait_code),
        .rx_ie(rx_ie), .tx_ie(tx_ie), .idle_ie(idle_ie), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
        .rx_rd(rx_rd), .soft_rst(soft_rst), .force_high(force_high), .sdi(sdi),
        .sclk(sclk), .sdo(sdo), .rx_data(rx_data), .rx_full(rx_full), .rx_ovr(rx_ovr),
        .tx_empty(tx_empty), .tx_idle(tx_idle), .rx_irq(rx_irq), .tx_irq(tx_irq)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // stimulus: tick every second cycle, sdi source select
    bit tick_en = 1'b1;
    int sdi_mode = 0;   // 0 loopback, 1 constant one, 2 pseudo-random
    int cyc_n = 0;
    logic [7:0] lfsr = 8'h5B;
    always begin
        @(posedge clk); #2;
        cyc_n++;
        tick = tick_en && (cyc_n % 2 == 0);
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        case (sdi_mode)
            0: sdi = sdo;
            1: sdi = 1'b1;
            default: sdi = lfsr[0];
        endcase
    end

    // behavioural reference model
    function automatic int len_of(input logic [2:0] c);
        if (c == 3'd1) return 5;
        if (c == 3'd2) return 6;
        if (c == 3'd3) return 7;
        if (c == 3'd4) return 9;
        return 8;
    endfunction

    int   m_st, m_gap, m_acc;
    bit   m_sclk, m_sdo, m_valid, m_full, m_ovr;
    logic [8:0] m_thr, m_rdata;
    bit   m_bits[$];

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_gap = 0; m_acc = 0; m_sclk = 1; m_sdo = 1; m_valid = 0;
            m_full = 0; m_ovr = 0; m_thr = '1; m_rdata = '0; m_bits.delete();
        end else begin
            bit wr_ok, done, was_full;
            wr_ok = tx_wr && !m_valid && !soft_rst;
            done = 0;
            was_full = m_full;
            if (soft_rst) begin
                m_st = 0; m_sclk = 1; m_bits.delete(); m_valid = 0; m_ovr = 0;
            end else if (tick) begin
                if (m_st == 0) begin
                    if (m_valid) begin
                        m_bits.delete();
                        for (int k = len_of(len_code) - 1; k >= 0; k--) m_bits.push_back(m_thr[k]);
                        m_valid = 0; m_acc = 0; m_sclk = 0; m_sdo = m_bits.pop_front(); m_st = 1;
                    end
                end else if (m_st == 1) begin
                    if (m_sclk) begin
                        m_sclk = 0; m_sdo = m_bits.pop_front();
                    end else begin
                        m_sclk = 1;
                        m_acc = (m_acc << 1) | int'(sdi);
                        if (m_bits.size() == 0) begin
                            done = 1;
                            if (wait_code == 0) m_st = 0;
                            else begin m_st = 2; m_gap = 2 * int'(wait_code); end
                        end
                    end
                end else begin
                    m_gap--;
                    if (m_gap == 0) m_st = 0;
                end
            end
            if (done && !was_full) begin m_rdata = 9'(m_acc); m_full = 1; end
            else if (rx_rd) m_full = 0;
            if (done && was_full) m_ovr = 1;
            if (force_high) m_sdo = 1;
            if (wr_ok) begin m_thr = tx_wdata; m_valid = 1; end
        end
    end

    // per-cycle comparison and gap monitor, away from the active edge
    int ncyc = 0, last_rise = -1, gapmax = 0;
    bit meas = 0, prev_sclk = 1;
    always @(negedge clk) begin
        bit e_idle;
        ncyc++;
        if (!rst) begin
            e_idle = !m_valid && (m_st == 0);
            chk(sclk == m_sclk, "R10 sclk", sclk, m_sclk);
            chk(sdo == m_sdo, "R10 sdo", sdo, m_sdo);
            chk(tx_empty == !m_valid, "R3 tx_empty", tx_empty, !m_valid);
            chk(tx_idle == e_idle, "R4 tx_idle", tx_idle, e_idle);
            chk(rx_full == m_full, "R6 rx_full", rx_full, m_full);
            chk(rx_ovr == m_ovr, "R7 rx_ovr", rx_ovr, m_ovr);
            chk(rx_data == m_rdata, "R5 rx_data", rx_data, m_rdata);
            chk(rx_irq == (m_full && rx_ie), "R6 rx_irq", rx_irq, m_full && rx_ie);
            chk(tx_irq == ((!m_valid && tx_ie) || (e_idle && idle_ie)), "R13 tx_irq",
                tx_irq, (!m_valid && tx_ie) || (e_idle && idle_ie));
        end
        if (meas) begin
            if (!prev_sclk && sclk) last_rise = ncyc;
            if (prev_sclk && !sclk && last_rise >= 0 && (ncyc - last_rise) > gapmax)
                gapmax = ncyc - last_rise;
        end
        prev_sclk = sclk;
    end

    task automatic cyc();
        @(posedge clk); #2;
    endtask

    task automatic send(input logic [8:0] w);
        while (!tx_empty) cyc();
        tx_wr = 1'b1; tx_wdata = w;
        cyc();
        tx_wr = 1'b0;
    endtask

    task automatic wait_idle();
        while (!tx_idle) cyc();
        cyc();
    endtask

    task automatic read_rx();
        rx_rd = 1'b1; cyc(); rx_rd = 1'b0;
    endtask

    task automatic len_case(input logic [2:0] code, input logic [8:0] exp, input string req);
        len_code = code;
        send(9'h1A5);
        wait_idle();
        chk(rx_data == exp, req, rx_data, exp);
        read_rx();
    endtask

    task automatic gap_case(input logic [1:0] w);
        wait_code = w; len_code = 3'b001;
        last_rise = -1; gapmax = 0; meas = 1;
        send(9'h015);
        send(9'h00A);
        wait_idle();
        meas = 0;
        chk(gapmax == 2 + 4 * int'(w), "R2 inter-word gap", gapmax, 2 + 4 * int'(w));
        read_rx();
    endtask

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        // R12 reset state
        chk(sclk == 1 && sdo == 1, "R12 line idle", {sclk, sdo}, 3);
        chk(tx_empty == 1 && tx_idle == 1, "R12 tx flags", {tx_empty, tx_idle}, 3);
        chk(rx_full == 0 && rx_ovr == 0 && rx_data == 0, "R12 rx state", {rx_full, rx_ovr, rx_data}, 0);

        // R5 zero fill with constant one input
        sdi_mode = 1; len_code = 3'b001;
        send(9'h000);
        wait_idle();
        chk(rx_data == 9'h01F, "R5 zero fill 5-bit", rx_data, 9'h01F);
        read_rx();

        // R1 lengths by loopback
        sdi_mode = 0;
        len_case(3'b000, 9'h0A5, "R1 len 8");
        len_case(3'b001, 9'h005, "R1 len 5");
        len_case(3'b010, 9'h025, "R1 len 6");
        len_case(3'b011, 9'h025, "R1 len 7");
        len_case(3'b100, 9'h1A5, "R1 len 9");
        len_case(3'b110, 9'h0A5, "R1 illegal as 8");

        // R2 gaps
        for (int w = 0; w < 4; w++) gap_case(2'(w));
        wait_code = 2'b00;

        // R6 receive interrupt
        rx_ie = 1'b1; len_code = 3'b000; sdi_mode = 2;
        send(9'h03C);
        wait_idle();
        chk(rx_irq == 1, "R6 rx_irq set", rx_irq, 1);
        read_rx();
        chk(rx_full == 0 && rx_irq == 0, "R6 cleared by read", {rx_full, rx_irq}, 0);
        rx_ie = 1'b0;

        // R7 overrun, cleared by R8 soft reset
        sdi_mode = 0;
        send(9'h011); wait_idle();
        send(9'h022); wait_idle();
        chk(rx_ovr == 1 && rx_data == 9'h011, "R7 overrun keeps word", rx_data, 9'h011);
        read_rx();
        soft_rst = 1'b1; cyc(); soft_rst = 1'b0;
        chk(rx_ovr == 0, "R8 soft reset clears overrun", rx_ovr, 0);

        // R11 write while full ignored, R3 empty flag
        tick_en = 1'b0; cyc(); cyc();
        tx_wr = 1'b1; tx_wdata = 9'h033; cyc(); tx_wr = 1'b0;
        chk(tx_empty == 0, "R3 cleared by write", tx_empty, 0);
        tx_ie = 1'b0; idle_ie = 1'b1;
        chk(tx_irq == 0, "R13 busy no idle irq", tx_irq, 0);
        tx_wr = 1'b1; tx_wdata = 9'h044; cyc(); tx_wr = 1'b0;
        tick_en = 1'b1;
        wait_idle();
        chk(rx_data == 9'h033, "R11 second write ignored", rx_data, 9'h033);
        chk(tx_irq == 1, "R13 idle irq", tx_irq, 1);
        idle_ie = 1'b0; tx_ie = 1'b1; cyc();
        chk(tx_irq == 1, "R13 empty irq", tx_irq, 1);
        tx_ie = 1'b0;
        read_rx();

        // R10 last bit held, R9 force high
        send(9'h0A4);
        wait_idle();
        chk(sdo == 0, "R10 last bit stays", sdo, 0);
        force_high = 1'b1; cyc(); force_high = 1'b0;
        chk(sdo == 1, "R9 force high", sdo, 1);
        read_rx();

        // R8 soft reset mid-word
        send(9'h0F3);
        repeat (5) cyc();
        soft_rst = 1'b1; cyc(); soft_rst = 1'b0;
        chk(sclk == 1 && tx_empty == 1 && tx_idle == 1, "R8 abort", {sclk, tx_empty, tx_idle}, 7);
        chk(rx_full == 0, "R8 no word stored", rx_full, 0);

        // random traffic against the model
        sdi_mode = 2;
        for (int i = 0; i < 12; i++) begin
            len_code = 3'(i % 5); wait_code = 2'(i % 4);
            send(9'(i * 37 + 5));
            if (i % 3 == 2) begin wait_idle(); read_rx(); end
        end
        wait_idle();
        repeat (4) cyc();

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule